// File: doc/BRIEF.md
# Dual-Lane Full-Duplex Serial Data Path

This block is the shifting core of a serial peripheral port that can move data on one or two lanes in each direction. It reads outgoing words from a show-ahead transmit FIFO and writes received words into a receive FIFO. In dual mode, each frame carries two consecutive transmit words side by side, one per output lane. The two words received on the input lanes in the same bit times are written back in a fixed order: lane 0 first, then lane 1.

When the port is master, it generates the serial clock itself. When it is slave, it synchronises an externally driven clock and reacts to its edges. The role decides which pins act as the output lanes and which as the input lanes. Bits travel most significant first. Data is sampled on the rising serial clock edge and changed on the falling edge, and the idle clock level is low. Register access and DMA handling sit outside this block.

Top module: `duo_spi_lane_path`

## Requirements
- R1: While reset is asserted, and after it until a frame starts, tx_pop, rx_push, sclk_o, mosi_o and miso_o are all low.
- R2: A frame starts only when cfg_enable is high, tx_empty is low and rx_full is high-free (low). While rx_full is high or cfg_enable is low, no word is popped and no clock edge is produced.
- R3: In dual mode a frame pops two words. If only the first is available, the block pops it and then waits, with no serial clock edge, until the second arrives.
- R4: As master, the first popped word of a frame is shifted out on mosi_o[0] and the second on mosi_o[1]. Each is sent MSB first, valid at every rising sclk_o edge.
- R5: As master in dual mode, the word sampled from miso_i[0] is pushed into the receive FIFO, and on the very next cycle the word from miso_i[1] is pushed.
- R6: As slave, the transmit words go out on miso_o[0] and miso_o[1] and the received words come from mosi_i[0] and mosi_i[1]. The FIFO order is the same as for the master.
- R7: With cfg_dual low, only lane 0 carries data. Lane 1 outputs (mosi_o[1], miso_o[1]) stay low, and exactly one word is popped and one pushed per frame.
- R8: As master, miso_o stays low. As slave, mosi_o and sclk_o stay low.
- R9: As master, sclk_o idles low and makes exactly WORD_W rising edges per frame, each clock phase lasting HALF_DIV cycles.
- R10: As slave, the block shifts on the edges of sclk_i after a two-flop synchroniser. The remote clock phases must each last at least four system cycles.
- R11: tx_pop is never asserted while tx_empty is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Allows new frames to start |
| cfg_master | input | 1 | 1 = master role, 0 = slave role |
| cfg_dual | input | 1 | 1 = two lanes per direction |
| tx_empty | input | 1 | Transmit FIFO has no word |
| tx_data | input | WORD_W | Head word of transmit FIFO (show-ahead) |
| tx_pop | output | 1 | Removes the head word of the transmit FIFO |
| rx_full | input | 1 | Receive FIFO cannot take a frame |
| rx_push | output | 1 | Writes rx_data into the receive FIFO |
| rx_data | output | WORD_W | Received word |
| sclk_o | output | 1 | Serial clock driven as master |
| sclk_i | input | 1 | Serial clock received as slave |
| mosi_o | output | 2 | Master data out, lanes 1:0 |
| mosi_i | input | 2 | Slave data in, lanes 1:0 |
| miso_o | output | 2 | Slave data out, lanes 1:0 |
| miso_i | input | 2 | Master data in, lanes 1:0 |

## Verification
The bench builds the block with WORD_W = 4 and HALF_DIV = 2. With these values every word value is small enough to sweep. In master dual mode all 256 transmit pairs are sent, each against a distinct, arithmetically derived peer pair, so every lane mapping and every receive ordering is checked. The short clock phase keeps each master frame near twenty cycles. That leaves room for slave sweeps under a slow remote clock and for the stall cases on a missing second word, a full receive FIFO and a disabled port.

// File: rtl/dlsp_pkg.sv
package dlsp_pkg;
    timeunit 1ns; timeprecision 1ps;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT1,
        ST_SHIFT,
        ST_PUSH0,
        ST_PUSH1
    } dlsp_state_e;

    localparam int LANES = 2;
endpackage

// File: rtl/dlsp_sclk_gen.sv
module dlsp_sclk_gen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic is_master,
    input  logic run,
    input  logic sclk_in,
    output logic sclk_out,
    output logic rise,
    output logic fall
);
    timeunit 1ns; timeprecision 1ps;

    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             sclk;
        logic [2:0]       sync;
    } gen_state_t;

    gen_state_t q, d;

    always_comb begin
        d      = q;
        rise   = 1'b0;
        fall   = 1'b0;
        d.sync = {q.sync[1:0], sclk_in};
        if (is_master) begin
            if (run) begin
                if (q.cnt == DIV_W'(HALF_DIV - 1)) begin
                    d.cnt  = '0;
                    d.sclk = ~q.sclk;
                    rise   = ~q.sclk;
                    fall   = q.sclk;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end else begin
                d.cnt  = '0;
                d.sclk = 1'b0;
            end
        end else begin
            d.cnt  = '0;
            d.sclk = 1'b0;
            rise   = run &&  q.sync[1] && !q.sync[2];
            fall   = run && !q.sync[1] &&  q.sync[2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk_out = q.sclk;
endmodule

// File: rtl/dlsp_lane.sv
module dlsp_lane #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              shift,
    input  logic              sample,
    input  logic              in_bit,
    output logic              out_bit,
    output logic [WORD_W-1:0] rx_word
);
    timeunit 1ns; timeprecision 1ps;

    typedef struct packed {
        logic [WORD_W-1:0] tx;
        logic [WORD_W-1:0] rx;
    } lane_state_t;

    lane_state_t q, d;

    always_comb begin
        d = q;
        if (load)       d.tx = load_word;
        else if (shift) d.tx = {q.tx[WORD_W-2:0], 1'b0};
        if (sample)     d.rx = {q.rx[WORD_W-2:0], in_bit};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_bit = q.tx[WORD_W-1];
    assign rx_word = q.rx;
endmodule

// File: rtl/duo_spi_lane_path.sv
module duo_spi_lane_path
    import dlsp_pkg::*;
#(
    parameter int WORD_W   = 8,
    parameter int HALF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_master,
    input  logic              cfg_dual,
    input  logic              tx_empty,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_pop,
    input  logic              rx_full,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_data,
    output logic              sclk_o,
    input  logic              sclk_i,
    output logic [1:0]        mosi_o,
    input  logic [1:0]        mosi_i,
    output logic [1:0]        miso_o,
    input  logic [1:0]        miso_i
);
    timeunit 1ns; timeprecision 1ps;

    localparam int CNT_W = $clog2(WORD_W + 1);

    typedef struct packed {
        dlsp_state_e      state;
        logic [CNT_W-1:0] bits;
    } path_state_t;

    path_state_t q, d;

    logic              run, rise, fall;
    logic              lane_shift, lane_sample;
    logic [LANES-1:0]  lane_load, lane_bit, lane_in, lane_out;
    logic [WORD_W-1:0] lane_rx [LANES];

    dlsp_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_master (cfg_master),
        .run       (run),
        .sclk_in   (sclk_i),
        .sclk_out  (sclk_o),
        .rise      (rise),
        .fall      (fall)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam bit IS_BASE = (l == 0);
        dlsp_lane #(.WORD_W(WORD_W)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (lane_load[l]),
            .load_word (tx_data),
            .shift     (lane_shift),
            .sample    (lane_sample),
            .in_bit    (lane_in[l]),
            .out_bit   (lane_bit[l]),
            .rx_word   (lane_rx[l])
        );
        assign lane_in[l]  = cfg_master ? miso_i[l] : mosi_i[l];
        assign lane_out[l] = (q.state == ST_SHIFT) && (IS_BASE || cfg_dual) && lane_bit[l];
    end

    assign mosi_o = cfg_master ? lane_out : '0;
    assign miso_o = cfg_master ? '0 : lane_out;
    assign run    = (q.state == ST_SHIFT);

    always_comb begin
        d           = q;
        tx_pop      = 1'b0;
        rx_push     = 1'b0;
        rx_data     = lane_rx[0];
        lane_load   = '0;
        lane_shift  = 1'b0;
        lane_sample = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (cfg_enable && !tx_empty && !rx_full) begin
                    tx_pop       = 1'b1;
                    lane_load[0] = 1'b1;
                    d.bits       = '0;
                    d.state      = cfg_dual ? ST_WAIT1 : ST_SHIFT;
                end
            end
            ST_WAIT1: begin
                if (!tx_empty) begin
                    tx_pop       = 1'b1;
                    lane_load[1] = 1'b1;
                    d.state      = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (rise) begin
                    lane_sample = 1'b1;
                    d.bits      = q.bits + 1'b1;
                end
                if (fall) begin
                    if (q.bits == CNT_W'(WORD_W)) d.state = ST_PUSH0;
                    else                         lane_shift = 1'b1;
                end
            end
            ST_PUSH0: begin
                rx_push = 1'b1;
                rx_data = lane_rx[0];
                d.state = cfg_dual ? ST_PUSH1 : ST_IDLE;
            end
            ST_PUSH1: begin
                rx_push = 1'b1;
                rx_data = lane_rx[1];
                d.state = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.bits  <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/dlsp_checker.sv
module dlsp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_master,
    input logic       cfg_dual,
    input logic       tx_empty,
    input logic       tx_pop,
    input logic       rx_push,
    input logic       sclk_o,
    input logic [1:0] mosi_o,
    input logic [1:0] miso_o
);
    timeunit 1ns; timeprecision 1ps;

    p_pop_has_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty);

    p_lane1_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_dual |-> (!mosi_o[1] && !miso_o[1]));

    p_master_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_master |-> (miso_o == 2'b00));

    p_slave_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_master |-> (mosi_o == 2'b00 && !sclk_o));

    // R5: the first write of a dual pair is followed at once by the second
    p_push_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dual && rx_push && !$past(rx_push)) |=> rx_push);
endmodule

bind duo_spi_lane_path dlsp_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_master (cfg_master),
    .cfg_dual   (cfg_dual),
    .tx_empty   (tx_empty),
    .tx_pop     (tx_pop),
    .rx_push    (rx_push),
    .sclk_o     (sclk_o),
    .mosi_o     (mosi_o),
    .miso_o     (miso_o)
);

// File: tb/duo_spi_lane_path_tb.sv
module duo_spi_lane_path_tb;
    timeunit 1ns; timeprecision 1ps;

    localparam int W    = 4;
    localparam int HALF = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic cfg_enable = 1'b1, cfg_master = 1'b1, cfg_dual = 1'b1;
    logic rx_full = 1'b0, sclk_i = 1'b0;
    logic [1:0] mosi_i = 2'b00;
    logic tx_empty, tx_pop, rx_push, sclk_o;
    logic [W-1:0] tx_data, rx_data;
    logic [1:0] mosi_o, miso_o, miso_i;

    logic [W-1:0] txq [0:1023];
    logic [W-1:0] rxq [0:1023];
    int tx_wr = 0, tx_rd = 0, rx_cnt = 0;
    int n_chk = 0, n_fail = 0;

    assign tx_empty = (tx_rd == tx_wr);
    assign tx_data  = txq[tx_rd % 1024];

    always @(posedge clk) begin
        if (tx_pop) tx_rd <= tx_rd + 1;
        if (rx_push) begin
            rxq[rx_cnt % 1024] <= rx_data;
            rx_cnt <= rx_cnt + 1;
        end
    end

    // peer of the master: counts rising sclk_o edges, captures both lanes
    logic sclk_prev = 1'b0;
    int rises = 0, l1_high = 0, rise_base = 0;
    logic [W-1:0] cap0 = '0, cap1 = '0, pw0 = '0, pw1 = '0;
    always @(negedge clk) begin
        if (sclk_o && !sclk_prev) begin
            cap0  <= {cap0[W-2:0], mosi_o[0]};
            cap1  <= {cap1[W-2:0], mosi_o[1]};
            rises <= rises + 1;
            if (mosi_o[1]) l1_high <= l1_high + 1;
        end
        sclk_prev <= sclk_o;
    end

    function automatic logic pick(input logic [W-1:0] w, input int i);
        return (i >= 0 && i < W) ? w[W-1-i] : 1'b0;
    endfunction
    assign miso_i = {pick(pw1, rises - rise_base), pick(pw0, rises - rise_base)};

    duo_spi_lane_path #(.WORD_W(W), .HALF_DIV(HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_master(cfg_master),
        .cfg_dual(cfg_dual), .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_data), .sclk_o(sclk_o),
        .sclk_i(sclk_i), .mosi_o(mosi_o), .mosi_i(mosi_i), .miso_o(miso_o), .miso_i(miso_i)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic put(input logic [W-1:0] w);
        txq[tx_wr % 1024] = w;
        tx_wr++;
    endtask

    task automatic wait_rx(input int target);
        for (int t = 0; t < 400 && rx_cnt < target; t++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic mframe(input bit dual, input logic [W-1:0] a, b, p0, p1);
        int rb, lb, rxb;
        rb = rises; lb = l1_high; rxb = rx_cnt;
        pw0 = p0; pw1 = p1; rise_base = rises;
        put(a);
        if (dual) put(b);
        wait_rx(rxb + (dual ? 2 : 1));
        chk(rises - rb == W, "R9 rising edges", rises - rb, W);
        chk(sclk_o == 1'b0, "R9 clock idle low", sclk_o, 0);
        chk(cap0 == a, "R4 lane0 word", cap0, a);
        chk(rxq[rxb % 1024] == p0, "R5 lane0 written first", rxq[rxb % 1024], p0);
        if (dual) begin
            chk(cap1 == b, "R4 lane1 word", cap1, b);
            chk(rxq[(rxb + 1) % 1024] == p1, "R5 lane1 written second", rxq[(rxb + 1) % 1024], p1);
            chk(rx_cnt == rxb + 2, "R5 two writes", rx_cnt - rxb, 2);
        end else begin
            chk(l1_high == lb, "R7 lane1 low", l1_high - lb, 0);
            chk(rx_cnt == rxb + 1, "R7 one write", rx_cnt - rxb, 1);
        end
    endtask

    task automatic sframe(input bit dual, input logic [W-1:0] a, b, p0, p1);
        logic [W-1:0] g0, g1;
        int rxb, bad;
        rxb = rx_cnt; bad = 0; g0 = '0; g1 = '0;
        put(a);
        if (dual) put(b);
        repeat (8) @(negedge clk);
        for (int i = 0; i < W; i++) begin
            mosi_i = {dual ? p1[W-1-i] : 1'b0, p0[W-1-i]};
            repeat (6) @(negedge clk);
            g0 = {g0[W-2:0], miso_o[0]};
            g1 = {g1[W-2:0], miso_o[1]};
            if (mosi_o != 2'b00 || sclk_o) bad++;
            sclk_i = 1'b1;
            repeat (6) @(negedge clk);
            sclk_i = 1'b0;
        end
        repeat (12) @(negedge clk);
        chk(bad == 0, "R8 slave master pins low", bad, 0);
        chk(g0 == a, "R6 R10 slave lane0 out", g0, a);
        chk(rxq[rxb % 1024] == p0, "R6 R10 slave lane0 in first", rxq[rxb % 1024], p0);
        if (dual) begin
            chk(g1 == b, "R6 slave lane1 out", g1, b);
            chk(rxq[(rxb + 1) % 1024] == p1, "R6 slave lane1 in second", rxq[(rxb + 1) % 1024], p1);
        end else begin
            chk(g1 == '0, "R7 slave lane1 low", g1, 0);
            chk(rx_cnt == rxb + 1, "R7 slave one write", rx_cnt - rxb, 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_up();
    end

    initial begin
        int rb, rd0, rxb;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(!tx_pop && !rx_push, "R1 no pop or push in reset", {tx_pop, rx_push}, 0);
        chk(!sclk_o && mosi_o == 0 && miso_o == 0, "R1 pins low in reset", {sclk_o, mosi_o, miso_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!sclk_o && mosi_o == 0 && miso_o == 0 && !tx_pop, "R1 idle after reset",
            {sclk_o, mosi_o, miso_o, tx_pop}, 0);

        // master dual sweep over all pairs
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                mframe(1'b1, W'(a), W'(b), W'(15 - a), W'(a ^ b ^ 6));

        // master single lane
        cfg_dual = 1'b0;
        for (int a = 0; a < 16; a++) mframe(1'b0, W'(a), '0, W'((a * 7 + 3) % 16), W'(15));

        // R3: second word missing
        cfg_dual = 1'b1;
        rb = rises; rxb = rx_cnt;
        pw0 = 4'h9; pw1 = 4'h4; rise_base = rises;
        put(4'hA);
        repeat (40) @(negedge clk);
        chk(rises == rb, "R3 no clock before second word", rises - rb, 0);
        chk(tx_rd == tx_wr, "R3 R11 first word popped only", tx_wr - tx_rd, 0);
        put(4'h5);
        wait_rx(rxb + 2);
        chk(cap0 == 4'hA && cap1 == 4'h5, "R3 pair sent after wait", {cap0, cap1}, 8'hA5);
        chk(rxq[rxb % 1024] == 4'h9 && rxq[(rxb + 1) % 1024] == 4'h4, "R3 pair received",
            {rxq[rxb % 1024], rxq[(rxb + 1) % 1024]}, 8'h94);

        // R2: receive FIFO full
        rx_full = 1'b1;
        rb = rises; rd0 = tx_rd; rxb = rx_cnt;
        pw0 = 4'h3; pw1 = 4'hC; rise_base = rises;
        put(4'h1); put(4'hE);
        repeat (40) @(negedge clk);
        chk(tx_rd == rd0, "R2 no pop while full", tx_rd - rd0, 0);
        chk(rises == rb, "R2 no clock while full", rises - rb, 0);
        rx_full = 1'b0;
        wait_rx(rxb + 2);
        chk(rx_cnt == rxb + 2, "R2 frame after full clears", rx_cnt - rxb, 2);

        // R2: disabled port
        cfg_enable = 1'b0;
        rb = rises; rd0 = tx_rd; rxb = rx_cnt;
        pw0 = 4'h7; pw1 = 4'h2; rise_base = rises;
        put(4'h6); put(4'hB);
        repeat (30) @(negedge clk);
        chk(tx_rd == rd0 && rises == rb, "R2 no activity when disabled", tx_rd - rd0, 0);
        cfg_enable = 1'b1;
        wait_rx(rxb + 2);
        chk(cap0 == 4'h6 && cap1 == 4'hB, "R2 frame after enable", {cap0, cap1}, 8'h6B);

        // slave role
        cfg_master = 1'b0;
        repeat (5) @(negedge clk);
        for (int a = 0; a < 16; a++) sframe(1'b1, W'(a), W'(a ^ 9), W'(15 - a), W'((a + 3) % 16));
        cfg_dual = 1'b0;
        for (int a = 0; a < 16; a += 2) sframe(1'b0, W'(a + 1), '0, W'(a ^ 12), '0);

        finish_up();
    end
endmodule